// File: doc/BRIEF.md
# Register File and Execute Unit with Immediate Operations

This block is the execute stage of a small 16-bit processor with four general-purpose registers. Each cycle it receives an already decoded operation: a class, an opcode field, a destination register select, a source register select and an 8-bit immediate. It reads the registers it needs, computes the new value and writes it back to the destination register at the clock edge. It also reports the value, a write strobe and a trap flag on registered outputs.

The classes cover several kinds of work. Register-register operations use the destination as the first operand. Single-operand operations act on the destination. Shift, rotate, bit and extend operations take a 4-bit amount or bit index. A sign-extended 8-bit add covers immediates. Two further classes replace one byte of a register. Results are committed at the edge that samples the operation, so the next operation in the following cycle already reads the new value. The four registers are held inside the block, with two read ports and one write port.

Top module: `regalu_exec`

## Requirements
- R1: Reset (synchronous, active high) clears all four registers to 0x0000 and drives `result`, `wr_en` and `trap` to 0 in the cycle after the reset edge.
- R2: Class RR (`op_class`=1) with `op_field[2:0]`=2 writes dst+src and with 3 writes dst-src to the destination register, both modulo 2^16. The source may equal the destination.
- R3: Class RR with code 4 writes dst AND src, code 5 writes dst OR src, and code 6 writes dst XOR src.
- R4: Class RR with code 0 raises `trap` for exactly the one cycle after the operation is sampled. It leaves `wr_en` low, leaves every register unchanged and shows the destination's value on `result`.
- R5: Class RR with code 1 (no-op) or code 7 (reserved) writes nothing, raises no trap and shows the destination's value on `result`.
- R6: Class UNARY (`op_class`=2) with `op_field[1:0]` 0 writes the bitwise inverse, 1 writes the two's-complement negation, 2 writes the value with its two bytes swapped, and 3 writes the value plus one.
- R7: Class IMMOP (`op_field` selects the operation, `imm8[3:0]` is the amount k) provides four shifts and rotates. Op 0 shifts left logically by k, op 1 shifts right logically, op 2 shifts right arithmetically, and op 3 rotates left. An amount of 0 leaves the value unchanged and still writes it.
- R8: Class IMMOP ops 4, 5 and 6 clear, set and invert respectively the single bit at index k. All other bits stay as they were.
- R9: Class IMMOP op 7 keeps bits k..0 and replaces every bit above k with a copy of bit k.
- R10: Class IMMOP ops 8 to 15 write nothing, raise no trap and show the destination's value.
- R11: Class ADDI (`op_class`=4) writes dst plus `imm8` sign-extended to 16 bits, wrapping modulo 2^16.
- R12: Class LDLO (`op_class`=5) replaces bits 7:0 of the destination with `imm8`. Class LDHI (6) replaces bits 15:8. The other byte is kept in both cases.
- R13: Every writing operation updates the register at the sampling edge and pulses `wr_en` in the next cycle, with `result` showing the written value. An operation presented in the very next cycle reads the updated value.
- R14: Class IDLE (0) and the unused class 7 write nothing, raise no trap and show the value of the register selected by `dst_sel` on `result`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| op_class | input | 3 | Operation class: 0 idle, 1 RR, 2 unary, 3 immop, 4 addi, 5 ldlo, 6 ldhi |
| op_field | input | 4 | Opcode within the class |
| dst_sel | input | 2 | Destination and first-operand register |
| src_sel | input | 2 | Second-operand register |
| imm8 | input | 8 | Immediate byte; bits 3:0 serve as amount or bit index for immop |
| result | output | 16 | Registered value that was written, or the destination's value when nothing is written |
| wr_en | output | 1 | Registered strobe: the previous operation wrote its destination |
| trap | output | 1 | Registered flag: the previous operation was a trap |

## Verification
Two things can happen in the same cycle. The write port can commit a register while the read ports feed the next operation that uses that same register. Both read ports can also select one register. The stimulus chains operations so that almost every step consumes the register written one cycle earlier, with no idle gap. It also includes same-register cases such as XOR and subtract of a register with itself, which must give zero. Each step's expected value is worked out by hand from the previous committed values. A stale read or a crossed port therefore shows up as a wrong `result` at that step or later.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

    localparam int DATA_W = 16;
    localparam int REG_N  = 4;
    localparam int ADDR_W = $clog2(REG_N);
    localparam int IMM_W  = 8;
    localparam int SH_W   = $clog2(DATA_W);
    localparam int OPF_W  = 4;

    typedef enum logic [2:0] {
        CLS_IDLE  = 3'd0,
        CLS_RR    = 3'd1,
        CLS_UNARY = 3'd2,
        CLS_IMMOP = 3'd3,
        CLS_ADDI  = 3'd4,
        CLS_LDLO  = 3'd5,
        CLS_LDHI  = 3'd6,
        CLS_SPARE = 3'd7
    } op_class_e;

    typedef enum logic [2:0] {
        RR_TRAP = 3'd0,
        RR_NOP  = 3'd1,
        RR_ADD  = 3'd2,
        RR_SUB  = 3'd3,
        RR_AND  = 3'd4,
        RR_OR   = 3'd5,
        RR_XOR  = 3'd6,
        RR_SPARE = 3'd7
    } rr_op_e;

    typedef enum logic [1:0] {
        UN_NOT  = 2'd0,
        UN_NEG  = 2'd1,
        UN_SWAP = 2'd2,
        UN_INC  = 2'd3
    } un_op_e;

    localparam logic [OPF_W-1:0] IM_LSL = 4'd0;
    localparam logic [OPF_W-1:0] IM_LSR = 4'd1;
    localparam logic [OPF_W-1:0] IM_ASR = 4'd2;
    localparam logic [OPF_W-1:0] IM_ROL = 4'd3;
    localparam logic [OPF_W-1:0] IM_CLR = 4'd4;
    localparam logic [OPF_W-1:0] IM_SET = 4'd5;
    localparam logic [OPF_W-1:0] IM_TOG = 4'd6;
    localparam logic [OPF_W-1:0] IM_EXT = 4'd7;

    typedef struct packed {
        logic wr;
        logic trap;
    } exec_flags_t;

endpackage

// File: rtl/regalu_rf.sv
module regalu_rf #(
    parameter int DATA_W = regalu_pkg::DATA_W,
    parameter int REG_N  = regalu_pkg::REG_N,
    parameter int ADDR_W = $clog2(REG_N)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] rd_a_sel,
    input  logic [ADDR_W-1:0] rd_b_sel,
    output logic [DATA_W-1:0] rd_a,
    output logic [DATA_W-1:0] rd_b,
    input  logic              we,
    input  logic [ADDR_W-1:0] wr_sel,
    input  logic [DATA_W-1:0] wr_data
);

    logic [DATA_W-1:0] regs [REG_N];

    for (genvar g = 0; g < REG_N; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) begin
                regs[g] <= '0;
            end else if (we && (wr_sel == ADDR_W'(g))) begin
                regs[g] <= wr_data;
            end
        end
    end

    assign rd_a = regs[rd_a_sel];
    assign rd_b = regs[rd_b_sel];

endmodule

// File: rtl/regalu_rr.sv
module regalu_rr
    import regalu_pkg::*;
#(
    parameter int DATA_W = regalu_pkg::DATA_W
) (
    input  rr_op_e            op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] value,
    output exec_flags_t       flags
);

    always_comb begin
        value      = a;
        flags.wr   = 1'b1;
        flags.trap = 1'b0;
        case (op)
            RR_TRAP: begin
                flags.wr   = 1'b0;
                flags.trap = 1'b1;
            end
            RR_ADD:  value = a + b;
            RR_SUB:  value = a - b;
            RR_AND:  value = a & b;
            RR_OR:   value = a | b;
            RR_XOR:  value = a ^ b;
            default: flags.wr = 1'b0;
        endcase
    end

endmodule

// File: rtl/regalu_unary.sv
module regalu_unary
    import regalu_pkg::*;
#(
    parameter int DATA_W = regalu_pkg::DATA_W
) (
    input  un_op_e            op,
    input  logic [DATA_W-1:0] a,
    output logic [DATA_W-1:0] value
);

    localparam int HALF = DATA_W / 2;

    always_comb begin
        case (op)
            UN_NOT:  value = ~a;
            UN_NEG:  value = '0 - a;
            UN_SWAP: value = {a[HALF-1:0], a[DATA_W-1:HALF]};
            default: value = a + DATA_W'(1);
        endcase
    end

endmodule

// File: rtl/regalu_immop.sv
module regalu_immop
    import regalu_pkg::*;
#(
    parameter int DATA_W = regalu_pkg::DATA_W,
    parameter int SH_W   = $clog2(DATA_W),
    parameter int OPF_W  = regalu_pkg::OPF_W
) (
    input  logic [OPF_W-1:0]  op,
    input  logic [DATA_W-1:0] a,
    input  logic [SH_W-1:0]   amt,
    output logic [DATA_W-1:0] value,
    output logic              wr
);

    logic [2*DATA_W-1:0] dbl;
    logic [DATA_W-1:0]   bit_mask;
    logic [DATA_W-1:0]   ext_val;

    assign dbl      = {a, a} << amt;
    assign bit_mask = {{(DATA_W-1){1'b0}}, 1'b1} << amt;

    for (genvar g = 0; g < DATA_W; g++) begin : g_ext
        assign ext_val[g] = (g <= int'(amt)) ? a[g] : a[amt];
    end

    always_comb begin
        value = a;
        wr    = 1'b1;
        case (op)
            IM_LSL:  value = a << amt;
            IM_LSR:  value = a >> amt;
            IM_ASR:  value = DATA_W'($signed(a) >>> amt);
            IM_ROL:  value = dbl[2*DATA_W-1:DATA_W];
            IM_CLR:  value = a & ~bit_mask;
            IM_SET:  value = a | bit_mask;
            IM_TOG:  value = a ^ bit_mask;
            IM_EXT:  value = ext_val;
            default: wr = 1'b0;
        endcase
    end

endmodule

// File: rtl/regalu_byteimm.sv
module regalu_byteimm
    import regalu_pkg::*;
#(
    parameter int DATA_W = regalu_pkg::DATA_W,
    parameter int IMM_W  = regalu_pkg::IMM_W
) (
    input  op_class_e         cls,
    input  logic [DATA_W-1:0] a,
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] value
);

    localparam int EXT_W = DATA_W - IMM_W;

    logic [DATA_W-1:0] imm_sx;
    assign imm_sx = {{EXT_W{imm[IMM_W-1]}}, imm};

    always_comb begin
        case (cls)
            CLS_LDLO: value = {a[DATA_W-1:IMM_W], imm};
            CLS_LDHI: value = {imm, a[EXT_W-1:0]};
            default:  value = a + imm_sx;
        endcase
    end

endmodule

// File: rtl/regalu_exec.sv
module regalu_exec
    import regalu_pkg::*;
#(
    parameter int DATA_W = regalu_pkg::DATA_W,
    parameter int REG_N  = regalu_pkg::REG_N,
    parameter int IMM_W  = regalu_pkg::IMM_W,
    parameter int OPF_W  = regalu_pkg::OPF_W,
    localparam int ADDR_W = $clog2(REG_N),
    localparam int SH_W   = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        op_class,
    input  logic [OPF_W-1:0]  op_field,
    input  logic [ADDR_W-1:0] dst_sel,
    input  logic [ADDR_W-1:0] src_sel,
    input  logic [IMM_W-1:0]  imm8,
    output logic [DATA_W-1:0] result,
    output logic              wr_en,
    output logic              trap
);

    op_class_e         cls;
    logic [DATA_W-1:0] opnd_a;
    logic [DATA_W-1:0] opnd_b;
    logic [DATA_W-1:0] rr_val;
    exec_flags_t       rr_flags;
    logic [DATA_W-1:0] un_val;
    logic [DATA_W-1:0] im_val;
    logic              im_wr;
    logic [DATA_W-1:0] bi_val;
    logic [DATA_W-1:0] nxt_val;
    exec_flags_t       nxt_flags;

    assign cls = op_class_e'(op_class);

    regalu_rf #(.DATA_W(DATA_W), .REG_N(REG_N), .ADDR_W(ADDR_W)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .rd_a_sel(dst_sel),
        .rd_b_sel(src_sel),
        .rd_a    (opnd_a),
        .rd_b    (opnd_b),
        .we      (nxt_flags.wr),
        .wr_sel  (dst_sel),
        .wr_data (nxt_val)
    );

    regalu_rr #(.DATA_W(DATA_W)) u_rr (
        .op   (rr_op_e'(op_field[2:0])),
        .a    (opnd_a),
        .b    (opnd_b),
        .value(rr_val),
        .flags(rr_flags)
    );

    regalu_unary #(.DATA_W(DATA_W)) u_unary (
        .op   (un_op_e'(op_field[1:0])),
        .a    (opnd_a),
        .value(un_val)
    );

    regalu_immop #(.DATA_W(DATA_W), .SH_W(SH_W), .OPF_W(OPF_W)) u_immop (
        .op   (op_field),
        .a    (opnd_a),
        .amt  (imm8[SH_W-1:0]),
        .value(im_val),
        .wr   (im_wr)
    );

    regalu_byteimm #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_byteimm (
        .cls  (cls),
        .a    (opnd_a),
        .imm  (imm8),
        .value(bi_val)
    );

    always_comb begin
        nxt_val        = opnd_a;
        nxt_flags.wr   = 1'b0;
        nxt_flags.trap = 1'b0;
        case (cls)
            CLS_RR: begin
                nxt_val   = rr_val;
                nxt_flags = rr_flags;
            end
            CLS_UNARY: begin
                nxt_val      = un_val;
                nxt_flags.wr = 1'b1;
            end
            CLS_IMMOP: begin
                nxt_val      = im_val;
                nxt_flags.wr = im_wr;
            end
            CLS_ADDI, CLS_LDLO, CLS_LDHI: begin
                nxt_val      = bi_val;
                nxt_flags.wr = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            result <= '0;
            wr_en  <= 1'b0;
            trap   <= 1'b0;
        end else begin
            result <= nxt_val;
            wr_en  <= nxt_flags.wr;
            trap   <= nxt_flags.trap;
        end
    end

endmodule

// File: rtl/regalu_exec_chk.sv
module regalu_exec_chk
    import regalu_pkg::*;
#(
    parameter int DATA_W = regalu_pkg::DATA_W,
    parameter int IMM_W  = regalu_pkg::IMM_W,
    parameter int OPF_W  = regalu_pkg::OPF_W,
    parameter int ADDR_W = regalu_pkg::ADDR_W
) (
    input logic              clk,
    input logic              rst,
    input logic [2:0]        op_class,
    input logic [OPF_W-1:0]  op_field,
    input logic [ADDR_W-1:0] dst_sel,
    input logic [ADDR_W-1:0] src_sel,
    input logic [IMM_W-1:0]  imm8,
    input logic [DATA_W-1:0] result,
    input logic              wr_en,
    input logic              trap
);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        rst |=> (result == '0 && !wr_en && !trap)); // R1

    AST_TRAP_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        trap |-> !wr_en); // R4

    AST_TRAP_SOURCE: assert property (@(posedge clk) disable iff (rst)
        trap |-> ($past(!rst) && $past(op_class) == CLS_RR && $past(op_field[2:0]) == RR_TRAP)); // R4

    AST_NOP_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_class) == CLS_RR &&
         ($past(op_field[2:0]) == RR_NOP || $past(op_field[2:0]) == RR_SPARE))
        |-> (!wr_en && !trap)); // R5

    AST_XOR_SELF_ZERO: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_class) == CLS_RR && $past(op_field[2:0]) == RR_XOR &&
         $past(dst_sel) == $past(src_sel))
        |-> (result == '0 && wr_en)); // R3

    AST_IMMOP_SPARE_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_class) == CLS_IMMOP && $past(op_field[OPF_W-1]))
        |-> (!wr_en && !trap)); // R10

    AST_ADDI_WRITES: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_class) == CLS_ADDI) |-> (wr_en && !trap)); // R11

    AST_LDLO_BYTE: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && $past(op_class) == CLS_LDLO) |-> (result[IMM_W-1:0] == $past(imm8) && wr_en)); // R12

    AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (rst)
        ($past(!rst) && ($past(op_class) == CLS_IDLE || $past(op_class) == CLS_SPARE))
        |-> (!wr_en && !trap)); // R14

endmodule

bind regalu_exec regalu_exec_chk u_chk (
    .clk     (clk),
    .rst     (rst),
    .op_class(op_class),
    .op_field(op_field),
    .dst_sel (dst_sel),
    .src_sel (src_sel),
    .imm8    (imm8),
    .result  (result),
    .wr_en   (wr_en),
    .trap    (trap)
);

// File: tb/regalu_exec_tb.sv
module regalu_exec_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 44;

    typedef struct packed {
        logic [2:0]  cls;
        logic [3:0]  op;
        logic [1:0]  dst;
        logic [1:0]  src;
        logic [7:0]  imm;
        logic [15:0] res;
        logic        wr;
        logic        trp;
        logic [7:0]  req;
    } vec_t;

    // classes: 0 idle, 1 RR, 2 unary, 3 immop, 4 addi, 5 ldlo, 6 ldhi, 7 spare
    localparam vec_t VECS [NVEC] = '{
        {3'd5, 4'd0, 2'd0, 2'd0, 8'h34, 16'h0034, 1'b1, 1'b0, 8'd12}, // R12 ldlo r0
        {3'd6, 4'd0, 2'd0, 2'd0, 8'h12, 16'h1234, 1'b1, 1'b0, 8'd12}, // R12 ldhi keeps low
        {3'd5, 4'd0, 2'd1, 2'd0, 8'hFF, 16'h00FF, 1'b1, 1'b0, 8'd12}, // R12
        {3'd6, 4'd0, 2'd1, 2'd0, 8'h80, 16'h80FF, 1'b1, 1'b0, 8'd13}, // R13 back to back
        {3'd1, 4'd2, 2'd0, 2'd1, 8'h00, 16'h9333, 1'b1, 1'b0, 8'd2},  // R2 add
        {3'd1, 4'd3, 2'd1, 2'd0, 8'h00, 16'hEDCC, 1'b1, 1'b0, 8'd2},  // R2 sub wraps
        {3'd1, 4'd4, 2'd0, 2'd1, 8'h00, 16'h8100, 1'b1, 1'b0, 8'd3},  // R3 and
        {3'd1, 4'd5, 2'd0, 2'd1, 8'h00, 16'hEDCC, 1'b1, 1'b0, 8'd3},  // R3 or
        {3'd1, 4'd6, 2'd0, 2'd1, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd3},  // R3 xor
        {3'd5, 4'd0, 2'd2, 2'd0, 8'h0F, 16'h000F, 1'b1, 1'b0, 8'd12}, // R12
        {3'd1, 4'd0, 2'd2, 2'd1, 8'h00, 16'h000F, 1'b0, 1'b1, 8'd4},  // R4 trap
        {3'd0, 4'd0, 2'd2, 2'd0, 8'h00, 16'h000F, 1'b0, 1'b0, 8'd4},  // R4 trap gone, r2 kept
        {3'd1, 4'd1, 2'd1, 2'd2, 8'h00, 16'hEDCC, 1'b0, 1'b0, 8'd5},  // R5 nop
        {3'd1, 4'd7, 2'd1, 2'd2, 8'h00, 16'hEDCC, 1'b0, 1'b0, 8'd5},  // R5 reserved
        {3'd0, 4'd0, 2'd1, 2'd0, 8'h00, 16'hEDCC, 1'b0, 1'b0, 8'd5},  // R5 r1 unchanged
        {3'd2, 4'd0, 2'd2, 2'd0, 8'h00, 16'hFFF0, 1'b1, 1'b0, 8'd6},  // R6 not
        {3'd2, 4'd1, 2'd2, 2'd0, 8'h00, 16'h0010, 1'b1, 1'b0, 8'd6},  // R6 neg
        {3'd2, 4'd2, 2'd2, 2'd0, 8'h00, 16'h1000, 1'b1, 1'b0, 8'd6},  // R6 swap
        {3'd2, 4'd3, 2'd2, 2'd0, 8'h00, 16'h1001, 1'b1, 1'b0, 8'd6},  // R6 inc
        {3'd3, 4'd0, 2'd1, 2'd0, 8'h04, 16'hDCC0, 1'b1, 1'b0, 8'd7},  // R7 lsl
        {3'd3, 4'd1, 2'd1, 2'd0, 8'h04, 16'h0DCC, 1'b1, 1'b0, 8'd7},  // R7 lsr
        {3'd6, 4'd0, 2'd3, 2'd0, 8'h96, 16'h9600, 1'b1, 1'b0, 8'd12}, // R12
        {3'd5, 4'd0, 2'd3, 2'd0, 8'h5A, 16'h965A, 1'b1, 1'b0, 8'd12}, // R12
        {3'd3, 4'd2, 2'd3, 2'd0, 8'h04, 16'hF965, 1'b1, 1'b0, 8'd7},  // R7 asr
        {3'd3, 4'd3, 2'd3, 2'd0, 8'h08, 16'h65F9, 1'b1, 1'b0, 8'd7},  // R7 rol
        {3'd3, 4'd3, 2'd3, 2'd0, 8'hF0, 16'h65F9, 1'b1, 1'b0, 8'd7},  // R7 amount 0, upper imm ignored
        {3'd3, 4'd4, 2'd3, 2'd0, 8'h00, 16'h65F8, 1'b1, 1'b0, 8'd8},  // R8 clr bit 0
        {3'd3, 4'd5, 2'd3, 2'd0, 8'h0F, 16'hE5F8, 1'b1, 1'b0, 8'd8},  // R8 set bit 15
        {3'd3, 4'd6, 2'd3, 2'd0, 8'h0F, 16'h65F8, 1'b1, 1'b0, 8'd8},  // R8 tog bit 15
        {3'd3, 4'd6, 2'd3, 2'd0, 8'h03, 16'h65F0, 1'b1, 1'b0, 8'd8},  // R8 tog bit 3
        {3'd3, 4'd7, 2'd3, 2'd0, 8'h07, 16'hFFF0, 1'b1, 1'b0, 8'd9},  // R9 ext from 7
        {3'd3, 4'd7, 2'd1, 2'd0, 8'h0B, 16'hFDCC, 1'b1, 1'b0, 8'd9},  // R9 ext from 11
        {3'd3, 4'd7, 2'd1, 2'd0, 8'h0F, 16'hFDCC, 1'b1, 1'b0, 8'd9},  // R9 ext from 15
        {3'd3, 4'd9, 2'd1, 2'd0, 8'h03, 16'hFDCC, 1'b0, 1'b0, 8'd10}, // R10
        {3'd3, 4'd15, 2'd1, 2'd0, 8'h01, 16'hFDCC, 1'b0, 1'b0, 8'd10}, // R10
        {3'd0, 4'd0, 2'd1, 2'd0, 8'h00, 16'hFDCC, 1'b0, 1'b0, 8'd10}, // R10 r1 unchanged
        {3'd4, 4'd0, 2'd0, 2'd0, 8'h7F, 16'h007F, 1'b1, 1'b0, 8'd11}, // R11 +127
        {3'd4, 4'd0, 2'd0, 2'd0, 8'h80, 16'hFFFF, 1'b1, 1'b0, 8'd11}, // R11 -128
        {3'd4, 4'd0, 2'd0, 2'd0, 8'h01, 16'h0000, 1'b1, 1'b0, 8'd11}, // R11 wrap
        {3'd4, 4'd0, 2'd2, 2'd0, 8'hFF, 16'h1000, 1'b1, 1'b0, 8'd11}, // R11 -1
        {3'd0, 4'd0, 2'd0, 2'd0, 8'h00, 16'h0000, 1'b0, 1'b0, 8'd14}, // R14 idle
        {3'd0, 4'd5, 2'd3, 2'd1, 8'hAA, 16'hFFF0, 1'b0, 1'b0, 8'd14}, // R14 idle
        {3'd7, 4'd2, 2'd3, 2'd1, 8'h11, 16'hFFF0, 1'b0, 1'b0, 8'd14}, // R14 spare class
        {3'd1, 4'd3, 2'd3, 2'd3, 8'h00, 16'h0000, 1'b1, 1'b0, 8'd2}   // R2 same register
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  op_class = '0;
    logic [3:0]  op_field = '0;
    logic [1:0]  dst_sel = '0;
    logic [1:0]  src_sel = '0;
    logic [7:0]  imm8 = '0;
    logic [15:0] result;
    logic        wr_en;
    logic        trap;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regalu_exec dut_i (
        .clk     (clk),
        .rst     (rst),
        .op_class(op_class),
        .op_field(op_field),
        .dst_sel (dst_sel),
        .src_sel (src_sel),
        .imm8    (imm8),
        .result  (result),
        .wr_en   (wr_en),
        .trap    (trap)
    );

    task automatic issue(input logic [2:0] c, input logic [3:0] o, input logic [1:0] d,
                         input logic [1:0] s, input logic [7:0] i);
        @(negedge clk);
        op_class = c;
        op_field = o;
        dst_sel  = d;
        src_sel  = s;
        imm8     = i;
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string tag, input logic [15:0] er, input logic ew, input logic et);
        checks++;
        if (result !== er || wr_en !== ew || trap !== et) begin
            errors++;
            $display("FAIL %s: result=%h wr_en=%b trap=%b expected result=%h wr_en=%b trap=%b",
                     tag, result, wr_en, trap, er, ew, et);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset outputs", 16'h0000, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;

        for (int k = 0; k < NVEC; k++) begin
            issue(VECS[k].cls, VECS[k].op, VECS[k].dst, VECS[k].src, VECS[k].imm);
            check($sformatf("R%0d vector %0d", VECS[k].req, k),
                  VECS[k].res, VECS[k].wr, VECS[k].trp);
        end

        // R4: two traps in a row, then the flag drops
        issue(3'd1, 4'd0, 2'd1, 2'd0, 8'h00);
        check("R4 first trap", 16'hFDCC, 1'b0, 1'b1);
        issue(3'd1, 4'd8, 2'd1, 2'd0, 8'h00);
        check("R4 second trap (op bit 3 unused)", 16'hFDCC, 1'b0, 1'b1);
        issue(3'd0, 4'd0, 2'd1, 2'd0, 8'h00);
        check("R4 trap cleared", 16'hFDCC, 1'b0, 1'b0);

        // R13: write then read in the very next cycle through the add
        issue(3'd5, 4'd0, 2'd2, 2'd0, 8'h01);
        check("R13 write r2 low byte", 16'h1001, 1'b1, 1'b0);
        issue(3'd1, 4'd2, 2'd2, 2'd2, 8'h00);
        check("R13 r2+r2 uses fresh value", 16'h2002, 1'b1, 1'b0);

        // R1: reset mid-run clears outputs and all registers
        @(negedge clk);
        rst = 1'b1;
        op_class = 3'd5;
        @(posedge clk);
        #1;
        check("R1 reset mid-run outputs", 16'h0000, 1'b0, 1'b0);
        @(negedge clk);
        rst = 1'b0;
        for (int r = 0; r < 4; r++) begin
            issue(3'd0, 4'd0, 2'(r), 2'd0, 8'h00);
            check($sformatf("R1 register %0d cleared", r), 16'h0000, 1'b0, 1'b0);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule